// File: doc/BRIEF.md
# Round-Robin Trigger Distributor

This block takes accepted level-1 trigger pulses and hands them out in turn to a set of downstream digitizer modules, so each module gets several trigger periods to finish encoding before it is triggered again. A rotating slot index chooses the module for each trigger. A fast-clear request is sent to the module that took the most recent trigger. The slot index then moves back to that module, so the next trigger reuses the module that was cleared.

Global busy goes back to the trigger supervisor. It is asserted while the module due for the next trigger reports front-end busy, or while the assignment log is full. Each accepted trigger writes one log entry into a small first-in first-out buffer. The entry holds a running trigger number, the chosen module and a snapshot of all busy lines. Readout drains these entries to check that the modules stay in step. The parameters are NMOD, the number of modules in rotation (2 to 16), PULSE_W, the output pulse length in cycles, and FIFO_DEPTH.

Top module: `rr_trig_dist`

## Requirements
- R1: After a synchronous reset, no trigger or fast-clear output is high, `fifo_empty` is 1, `fifo_ovf` is 0, the next slot is module 0, the trigger number is 0, and no fast clear is pending.
- R2: On a rising edge of `l1a_in` the trigger is accepted unless it is blocked. It is blocked when `busy_out` is high, or when `fclr_in` rises in the same cycle. An accepted trigger drives `trig_out[k]` high for exactly PULSE_W cycles, starting at the next clock edge, where k is the current slot. Slots run 0, 1, …, NMOD-1 and then back to 0. A level held high counts once.
- R3: `busy_out` is the combinational OR of `fe_busy[slot]` and FIFO full. Busy lines of other modules have no effect on it.
- R4: A trigger edge that arrives while `busy_out` is high produces no output pulse, does not advance the slot and writes no log entry.
- R5: A rising edge of `fclr_in` after an accepted trigger drives `fclr_out[m]` high for PULSE_W cycles, starting at the next clock edge. Here m is the module that took the most recent trigger. The slot returns to m, and the trigger number is not changed.
- R6: A fast-clear edge is ignored when no trigger has been accepted since reset or since the previous clear.
- R7: When `l1a_in` and `fclr_in` rise in the same cycle, the clear is carried out as in R5 and the trigger is dropped.
- R8: Each accepted trigger writes one entry, laid out MSB to LSB as {trigger number [15:0], module index [3:0], `fe_busy` sampled in that cycle}. The trigger number starts at 0 and goes up by one for each accepted trigger, wrapping after 65535.
- R9: When the FIFO is not empty, `rd_data` shows the oldest entry. A high `rd_en` at a clock edge removes that entry. A high `rd_en` on an empty FIFO has no effect.
- R10: When FIFO_DEPTH entries are stored, `busy_out` is high. A trigger edge that arrives while the FIFO is full sets `fifo_ovf`, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l1a_in | input | 1 | Level-1 accept, rising-edge sensitive |
| fclr_in | input | 1 | Fast-clear request, rising-edge sensitive |
| fe_busy | input | NMOD | Front-end busy, one line per module |
| rd_en | input | 1 | Remove the oldest log entry |
| trig_out | output | NMOD | Trigger pulse, one line per module |
| fclr_out | output | NMOD | Fast-clear pulse, one line per module |
| busy_out | output | 1 | Global busy sent to the trigger supervisor |
| rd_data | output | 20+NMOD | Oldest log entry |
| fifo_empty | output | 1 | Log is empty |
| fifo_ovf | output | 1 | Sticky flag: a trigger arrived while the log was full |

## Verification
The assertions assume reset is held from time zero until the first clock edges. They also assume `l1a_in` and `fclr_in` are ordinary levels sampled on the clock, and that a rising edge is any cycle where the line is 1 and was 0 on the previous cycle. The stimulus drives every input on the falling clock edge, after reset has been released. It spaces trigger and clear edges at least PULSE_W+1 cycles apart, so no pulse is restarted while it is still running. Busy lines change only between edges, so the busy value that gates a trigger is stable when that trigger is sampled.

// File: rtl/rr_trig_dist.sv
module rr_trig_dist #(
  parameter int NMOD       = 4,
  parameter int PULSE_W    = 3,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l1a_in,
  input  logic              fclr_in,
  input  logic [NMOD-1:0]   fe_busy,
  input  logic              rd_en,
  output logic [NMOD-1:0]   trig_out,
  output logic [NMOD-1:0]   fclr_out,
  output logic              busy_out,
  output logic [19+NMOD:0]  rd_data,
  output logic              fifo_empty,
  output logic              fifo_ovf
);
  localparam int EW = 20 + NMOD;
  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(PULSE_W + 1);
  localparam logic [3:0] LAST_SLOT = 4'(NMOD - 1);

  logic          l1a_q, fclr_q;
  logic [3:0]    slot, prev_slot;
  logic          armed;
  logic [15:0]   tnum;
  logic [EW-1:0] mem [FIFO_DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic [15:0]   busy_pad;

  wire l1a_rise  = l1a_in & ~l1a_q;
  wire fclr_rise = fclr_in & ~fclr_q;
  wire full      = (cnt == (AW+1)'(FIFO_DEPTH));
  wire do_clr    = fclr_rise & armed;
  wire accept    = l1a_rise & ~busy_out & ~fclr_rise;
  wire pop       = rd_en & ~fifo_empty;

  assign busy_pad   = 16'(fe_busy);
  assign busy_out   = busy_pad[slot] | full;
  assign fifo_empty = (cnt == '0);
  assign rd_data    = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      l1a_q  <= 1'b0;
      fclr_q <= 1'b0;
    end else begin
      l1a_q  <= l1a_in;
      fclr_q <= fclr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= '0;
      prev_slot <= '0;
      armed     <= 1'b0;
      tnum      <= '0;
    end else if (do_clr) begin
      slot  <= prev_slot;
      armed <= 1'b0;
    end else if (accept) begin
      prev_slot <= slot;
      slot      <= (slot == LAST_SLOT) ? 4'd0 : slot + 4'd1;
      armed     <= 1'b1;
      tnum      <= tnum + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= {tnum, slot, fe_busy};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (accept) wptr <= (wptr == AW'(FIFO_DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)    rptr <= (rptr == AW'(FIFO_DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({accept, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  fifo_ovf <= 1'b0;
    else if (l1a_rise & full) fifo_ovf <= 1'b1;
  end

  for (genvar i = 0; i < NMOD; i++) begin : g_mod
    logic [CW-1:0] tc, fc;
    always_ff @(posedge clk) begin
      if (rst)                           tc <= '0;
      else if (accept && slot == 4'(i))  tc <= CW'(PULSE_W);
      else if (tc != '0)                 tc <= tc - 1'b1;
    end
    always_ff @(posedge clk) begin
      if (rst)                               fc <= '0;
      else if (do_clr && prev_slot == 4'(i)) fc <= CW'(PULSE_W);
      else if (fc != '0)                     fc <= fc - 1'b1;
    end
    assign trig_out[i] = (tc != '0);
    assign fclr_out[i] = (fc != '0);
  end
endmodule

module rr_trig_dist_chk #(
  parameter int NMOD = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            l1a_in,
  input logic            fclr_in,
  input logic            rd_en,
  input logic            busy_out,
  input logic [NMOD-1:0] trig_out,
  input logic [NMOD-1:0] fclr_out,
  input logic            fifo_empty,
  input logic            fifo_ovf
);
  logic            l1a_d, fclr_d;
  logic [NMOD-1:0] trig_d, fclr_od;

  always_ff @(posedge clk) begin
    if (rst) begin
      l1a_d <= 1'b0; fclr_d <= 1'b0; trig_d <= '0; fclr_od <= '0;
    end else begin
      l1a_d <= l1a_in; fclr_d <= fclr_in; trig_d <= trig_out; fclr_od <= fclr_out;
    end
  end

  a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trig_out & ~trig_d));

  a_r5_single_clear: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fclr_out & ~fclr_od));

  a_r4_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    (l1a_in && !l1a_d && busy_out) |=> ($countones(trig_out & ~trig_d) == 0));

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (fclr_in && !fclr_d) |=> ($countones(trig_out & ~trig_d) == 0));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    fifo_ovf |=> fifo_ovf);

  a_r9_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fifo_empty && !(l1a_in && !l1a_d)) |=> fifo_empty);
endmodule

bind rr_trig_dist rr_trig_dist_chk #(.NMOD(NMOD)) u_chk (.*);

// File: tb/tb_rr_trig_dist.sv
`timescale 1ns/1ps
module tb_rr_trig_dist;
  localparam int NMOD = 4;
  localparam int PW   = 3;
  localparam int DEP  = 8;
  localparam int EW   = 20 + NMOD;

  logic clk = 1'b0, rst = 1'b1;
  logic l1a = 1'b0, fclr = 1'b0, rd_en = 1'b0;
  logic [NMOD-1:0] fe_busy = '0;
  logic [NMOD-1:0] trig_out, fclr_out;
  logic busy_out, fifo_empty, fifo_ovf;
  logic [EW-1:0] rd_data;

  rr_trig_dist #(.NMOD(NMOD), .PULSE_W(PW), .FIFO_DEPTH(DEP)) dut (
    .clk(clk), .rst(rst), .l1a_in(l1a), .fclr_in(fclr), .fe_busy(fe_busy),
    .rd_en(rd_en), .trig_out(trig_out), .fclr_out(fclr_out), .busy_out(busy_out),
    .rd_data(rd_data), .fifo_empty(fifo_empty), .fifo_ovf(fifo_ovf));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, rises = 0;
  bit done = 0;
  int m_slot = 0, m_last = 0;
  bit m_armed = 0, m_ovf = 0;
  logic [15:0] m_num = '0;
  logic [EW-1:0] q[$];
  logic [NMOD-1:0] tprev = '0;

  always @(negedge clk) begin
    rises += $countones(trig_out & ~tprev);
    tprev = trig_out;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_edge(input bit l, input bit c, input string req);
    logic [NMOD-1:0] et = '0, ec = '0;
    bit acc;
    acc = l && !c && !(fe_busy[m_slot] || q.size() == DEP);
    if (l && q.size() == DEP) m_ovf = 1;
    if (c && m_armed) begin
      ec[m_last] = 1'b1; m_slot = m_last; m_armed = 0;
    end else if (acc) begin
      et[m_slot] = 1'b1;
      q.push_back({m_num, 4'(m_slot), fe_busy});
      m_num++; m_last = m_slot; m_armed = 1; m_slot = (m_slot + 1) % NMOD;
    end
    @(negedge clk); l1a = l; fclr = c;
    @(posedge clk); #1;
    chk({req, " trig"}, 64'(trig_out), 64'(et));
    chk({req, " clr"}, 64'(fclr_out), 64'(ec));
    @(negedge clk); l1a = 0; fclr = 0;
    for (int k = 2; k <= PW; k++) begin
      @(posedge clk); #1;
      chk({req, " trig width"}, 64'(trig_out), 64'(et));
      chk({req, " clr width"}, 64'(fclr_out), 64'(ec));
    end
    @(posedge clk); #1;
    chk({req, " trig end"}, 64'(trig_out), 64'd0);
    chk({req, " clr end"}, 64'(fclr_out), 64'd0);
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) begin
      @(negedge clk);
      chk({req, " not empty"}, 64'(fifo_empty), 64'd0);
      chk({req, " entry"}, 64'(rd_data), 64'(q.pop_front()));
      rd_en = 1;
      @(negedge clk); rd_en = 0;
    end
    @(negedge clk);
    chk({req, " empty"}, 64'(fifo_empty), 64'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 trig", 64'(trig_out), 0);
    chk("R1 clr", 64'(fclr_out), 0);
    chk("R1 empty", 64'(fifo_empty), 1);
    chk("R1 ovf", 64'(fifo_ovf), 0);
    chk("R1 busy", 64'(busy_out), 0);
    fe_busy = 4'b0001; #1;
    chk("R1 slot0 busy", 64'(busy_out), 1);
    fe_busy = 4'b0010; #1;
    chk("R3 other busy", 64'(busy_out), 0);
    fe_busy = '0;
    do_edge(0, 1, "R6 clear after reset");
  endtask

  task automatic t_rotation();
    for (int i = 0; i < 6; i++) do_edge(1, 0, "R2 rotation");
    drain("R8 rotation log");
  endtask

  task automatic t_long_hold();
    int r0;
    r0 = rises;
    q.push_back({m_num, 4'(m_slot), fe_busy});
    m_num++; m_last = m_slot; m_armed = 1; m_slot = (m_slot + 1) % NMOD;
    @(negedge clk); l1a = 1;
    repeat (10) @(negedge clk);
    l1a = 0;
    repeat (PW + 2) @(negedge clk);
    chk("R2 held level counts once", 64'(rises - r0), 64'd1);
    drain("R8 held log");
  endtask

  task automatic t_busy();
    int r0;
    @(negedge clk); fe_busy = '0; fe_busy[m_slot] = 1'b1; #1;
    chk("R3 busy from slot", 64'(busy_out), 1);
    r0 = rises;
    do_edge(1, 0, "R4 busy ignored");
    chk("R4 no pulse", 64'(rises - r0), 0);
    @(negedge clk); fe_busy = ~fe_busy; #1;
    chk("R3 others busy", 64'(busy_out), 0);
    do_edge(1, 0, "R4 same slot after busy");
    @(negedge clk); fe_busy = '0;
    drain("R8 busy snapshot");
  endtask

  task automatic t_clear();
    do_edge(1, 0, "R5 pre trig");
    do_edge(0, 1, "R5 clear");
    do_edge(1, 0, "R5 slot reused");
    do_edge(0, 1, "R5 clear again");
    do_edge(0, 1, "R6 double clear ignored");
    do_edge(1, 0, "R7 pre trig");
    do_edge(1, 1, "R7 both edges");
    do_edge(1, 0, "R7 slot reused");
    drain("R8 clear log");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEP; i++) do_edge(1, 0, "R10 fill");
    @(negedge clk);
    chk("R10 busy when full", 64'(busy_out), 1);
    chk("R10 ovf before", 64'(fifo_ovf), 0);
    do_edge(1, 0, "R10 trig when full");
    @(negedge clk);
    chk("R10 ovf set", 64'(fifo_ovf), 1);
    chk("R10 entry", 64'(rd_data), 64'(q.pop_front()));
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R10 busy after pop", 64'(busy_out), 0);
    chk("R10 ovf sticky", 64'(fifo_ovf), 1);
    drain("R9 drain");
  endtask

  task automatic t_empty_read();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk("R9 empty read", 64'(fifo_empty), 1);
    do_edge(1, 0, "R9 after empty read");
    drain("R9 log after empty read");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_rotation();
    t_long_hold();
    t_busy();
    t_clear();
    t_full();
    t_empty_read();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule